// File: doc/BRIEF.md
# Walking-Ones Data Bus Tester

This engine checks the wiring of a memory data bus from hardware, without a processor. A one-cycle start pulse launches a sequence of write/read pairs on a simple single-outstanding memory master port. Every pair targets one fixed location, the region base address. The word written first has only bit 0 set. After each successful read-back the set bit moves one position toward the most significant bit. The sequence ends once the set bit has passed the top of the word. For the default 32-bit bus this gives 32 pairs.

If a read returns anything other than the word just written, the engine stops at once. It then reports a failure together with the base address. If every pair matches, it reports a pass with a zero result address. A one-cycle done pulse marks the end of a test. The result outputs keep their values until the next test finishes. The memory may take any number of cycles to acknowledge each request.

Top module: `walk_bus_checker`

## Requirements
- R1: After a synchronous active-high reset, memReq, done and passFlag are 0 and failAddr is 0.
- R2: After an accepted start, write number k (counting from 0) carries the word with only bit k set (value 1 shifted left by k). On a passing run exactly DATA_W writes and DATA_W reads are issued.
- R3: At most one transaction is outstanding at a time. While memReq is high and memAck is low, memReq, memWe, memAddr and memWdata stay unchanged. Each write (memWe=1) is followed by a read (memWe=0) of the same word before the next write.
- R4: Every request drives memAddr equal to BASE_ADDR.
- R5: When read data differs from the word last written, no further request is issued. The test ends with passFlag=0 and failAddr=BASE_ADDR.
- R6: When all DATA_W read-backs match, the test ends with passFlag=1 and failAddr=0.
- R7: done is high for exactly one cycle, in the cycle after the final acknowledge. passFlag and failAddr hold their values until the next test ends.
- R8: A start pulse that arrives while a test is running has no effect on the sequence of requests or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| startPulse | input | 1 | Begins a test when the engine is idle |
| memReq | output | 1 | Memory request, held until acknowledged |
| memWe | output | 1 | 1 = write, 0 = read |
| memAddr | output | ADDR_W | Request address, always BASE_ADDR |
| memWdata | output | DATA_W | Current test word |
| memRdata | input | DATA_W | Read data, valid with memAck on a read |
| memAck | input | 1 | Completes the current request on the clock edge it is high |
| done | output | 1 | One-cycle end-of-test pulse |
| passFlag | output | 1 | 1 if the last test passed |
| failAddr | output | ADDR_W | BASE_ADDR after a failure, 0 after a pass |

## Verification
The checker asserts on every cycle that requests hold steady until acknowledged, that every address is the base, and that every written word is one-hot. It also asserts that done is a single-cycle pulse with no request beside it, and that a mismatching read acknowledge leads straight to a failing result. The bench scenarios show the behaviours that span a whole run: the exact order of walking words, the count of writes and reads, the step at which an injected stuck bit stops the run, and the immunity to a second start pulse. Those scenarios use random acknowledge latency and fault masks.

// File: rtl/walk_bus_pkg.sv
package walk_bus_pkg;
  typedef struct packed {
    logic loadWord;
    logic shiftWord;
    logic finishPass;
    logic finishFail;
  } walkStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WRITE = 2'd1,
    ST_READ  = 2'd2
  } walkState_t;
endpackage

// File: rtl/walk_bus_ctrl.sv
module walk_bus_ctrl
  import walk_bus_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         startPulse,
  input  logic         memAck,
  input  logic         mismatch,
  input  logic         lastStep,
  output logic         memReq,
  output logic         memWe,
  output walkStrobes_t strb
);
  walkState_t state, nextState;

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (startPulse) begin
          strb.loadWord = 1'b1;
          nextState     = ST_WRITE;
        end
      end
      ST_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memAck) nextState = ST_READ;
      end
      ST_READ: begin
        memReq = 1'b1;
        if (memAck) begin
          if (mismatch) begin
            strb.finishFail = 1'b1;
            nextState       = ST_IDLE;
          end else if (lastStep) begin
            strb.finishPass = 1'b1;
            nextState       = ST_IDLE;
          end else begin
            strb.shiftWord = 1'b1;
            nextState      = ST_WRITE;
          end
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/walk_bus_datapath.sv
module walk_bus_datapath
  import walk_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  walkStrobes_t      strb,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] testWord,
  output logic              mismatch,
  output logic              lastStep,
  output logic              done,
  output logic              passFlag,
  output logic [ADDR_W-1:0] failAddr
);
  localparam logic [DATA_W-1:0] FIRST_WORD = DATA_W'(1);

  assign mismatch = (memRdata != testWord);
  assign lastStep = testWord[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      testWord <= '0;
      done     <= 1'b0;
      passFlag <= 1'b0;
      failAddr <= '0;
    end else begin
      done <= 1'b0;
      if (strb.loadWord)       testWord <= FIRST_WORD;
      else if (strb.shiftWord) testWord <= testWord << 1;
      if (strb.finishPass) begin
        done     <= 1'b1;
        passFlag <= 1'b1;
        failAddr <= '0;
      end else if (strb.finishFail) begin
        done     <= 1'b1;
        passFlag <= 1'b0;
        failAddr <= BASE_ADDR;
      end
    end
  end
endmodule

// File: rtl/walk_bus_checker.sv
module walk_bus_checker
  import walk_bus_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startPulse,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              memAck,
  output logic              done,
  output logic              passFlag,
  output logic [ADDR_W-1:0] failAddr
);
  walkStrobes_t strb;
  logic mismatch, lastStep;

  assign memAddr = BASE_ADDR;

  walk_bus_ctrl u_ctrl (
    .clk(clk), .rst(rst), .startPulse(startPulse), .memAck(memAck),
    .mismatch(mismatch), .lastStep(lastStep),
    .memReq(memReq), .memWe(memWe), .strb(strb)
  );

  walk_bus_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .memRdata(memRdata),
    .testWord(memWdata), .mismatch(mismatch), .lastStep(lastStep),
    .done(done), .passFlag(passFlag), .failAddr(failAddr)
  );
endmodule

// File: rtl/walk_bus_checker_sva.sv
module walk_bus_checker_sva #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              startPulse,
  input logic              memReq,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic [DATA_W-1:0] memRdata,
  input logic              memAck,
  input logic              done,
  input logic              passFlag,
  input logic [ADDR_W-1:0] failAddr
);
  // R3: request held steady until acknowledged
  a_r3_req_hold: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck |=> memReq && $stable(memWe) && $stable(memAddr) && $stable(memWdata));

  // R3: an acknowledged write is followed by a read
  a_r3_write_then_read: assert property (@(posedge clk) disable iff (rst)
    memReq && memWe && memAck |=> memReq && !memWe);

  // R4: every request targets the base address
  a_r4_addr_base: assert property (@(posedge clk) disable iff (rst)
    memReq |-> memAddr == BASE_ADDR);

  // R2: written words are one-hot
  a_r2_onehot_word: assert property (@(posedge clk) disable iff (rst)
    memReq && memWe |-> $countones(memWdata) == 1);

  // R5: a mismatching read ends the test with a failure
  a_r5_fail_stop: assert property (@(posedge clk) disable iff (rst)
    memReq && !memWe && memAck && (memRdata != memWdata)
      |=> done && !passFlag && failAddr == BASE_ADDR && !memReq);

  // R7: done lasts one cycle with no request beside it
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |-> !memReq ##1 !done);

  // R7: results change only when a test ends
  a_r7_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> done || ($stable(passFlag) && $stable(failAddr)));

  // R8: a start during a pending request leaves it untouched
  a_r8_busy_start: assert property (@(posedge clk) disable iff (rst)
    memReq && !memAck && startPulse |=> memReq && $stable(memWdata));
endmodule

bind walk_bus_checker walk_bus_checker_sva #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_sva (.*);

// File: tb/tb_walk_bus_checker.sv
module tb_walk_bus_checker;
  localparam int DW = 32;
  localparam int AW = 32;
  localparam logic [AW-1:0] BASE = 32'hC000_0000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic startPulse = 1'b0;
  logic memReq, memWe, memAck = 1'b0, done, passFlag;
  logic [AW-1:0] memAddr, failAddr;
  logic [DW-1:0] memWdata, memRdata = '0;

  int total = 0, bad = 0, cycles = 0;
  logic [DW-1:0] stuckLow = '0, stuckHigh = '0, stored = '0;
  int maxDelay = 0, waitCnt = 0, writeIdx = 0, readCnt = 0;
  logic finished = 1'b0;

  walk_bus_checker #(.DATA_W(DW), .ADDR_W(AW), .BASE_ADDR(BASE)) dut (.*);

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int firstFail(input logic [DW-1:0] lo, input logic [DW-1:0] hi);
    for (int k = 0; k < DW; k++) begin
      logic [DW-1:0] w = DW'(1) << k;
      if (((w & ~lo) | hi) != w) return k;
    end
    return -1;
  endfunction

  // memory model with variable latency and fault masks
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      memAck = 1'b0;
      waitCnt = 0;
    end else if (memAck) begin
      memAck = 1'b0;
      waitCnt = $urandom_range(maxDelay, 0);
    end else if (memReq) begin
      if (waitCnt > 0) waitCnt--;
      else begin
        memAck = 1'b1;
        if (memWe) begin
          check("R2 write word", memWdata, DW'(1) << writeIdx);
          check("R4 write address", memAddr, BASE);
          writeIdx++;
          stored = (memWdata & ~stuckLow) | stuckHigh;
        end else begin
          check("R4 read address", memAddr, BASE);
          memRdata = stored;
          readCnt++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic runTest(input logic [DW-1:0] lo, input logic [DW-1:0] hi,
                         input int dly, input bit extraStart);
    int ff, expN, guard;
    stuckLow = lo; stuckHigh = hi; maxDelay = dly;
    writeIdx = 0; readCnt = 0;
    ff = firstFail(lo, hi);
    expN = (ff < 0) ? DW : ff + 1;
    @(negedge clk); startPulse = 1'b1;
    @(negedge clk); startPulse = 1'b0;
    if (extraStart) begin
      repeat (3) @(negedge clk);
      startPulse = 1'b1;   // R8: should be ignored
      @(negedge clk); startPulse = 1'b0;
    end
    guard = 0;
    while (!done && guard < 20000) begin @(negedge clk); guard++; end
    check("R7 done seen", done, 1);
    check("R6/R5 passFlag", passFlag, (ff < 0) ? 1 : 0);
    check("R6/R5 failAddr", failAddr, (ff < 0) ? 64'(0) : 64'(BASE));
    check("R2/R5 write count", writeIdx, expN);
    check("R3 read count", readCnt, expN);
    @(negedge clk);
    check("R7 done one cycle", done, 0);
    check("R5 no request after end", memReq, 0);
    repeat (3) @(negedge clk);
    check("R8 no restart", writeIdx, expN);
    check("R7 passFlag held", passFlag, (ff < 0) ? 1 : 0);
    check("R7 failAddr held", failAddr, (ff < 0) ? 64'(0) : 64'(BASE));
  endtask

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 memReq", memReq, 0);
    check("R1 done", done, 0);
    check("R1 passFlag", passFlag, 0);
    check("R1 failAddr", failAddr, 0);

    runTest('0, '0, 0, 1'b0);                 // R6 clean, zero latency
    runTest('0, '0, 4, 1'b1);                 // R6 with latency, R8 extra start
    runTest(DW'(1), '0, 2, 1'b0);             // R5 bit 0 stuck low: fails step 0
    runTest(DW'(1) << (DW-1), '0, 1, 1'b0);   // R5 top bit stuck low: last step
    runTest('0, DW'(1) << 5, 3, 1'b1);        // R5 bit 5 stuck high: fails step 0
    runTest('0, DW'(1), 0, 1'b0);             // R5 bit 0 stuck high: fails step 1
    runTest('0, '0, 1, 1'b0);                 // R7 pass after fail overwrites results

    for (int i = 0; i < 10; i++) begin
      logic [DW-1:0] lo = '0, hi = '0;
      int sel = $urandom_range(2, 0);
      if (sel == 1) lo = DW'(1) << $urandom_range(DW-1, 0);
      if (sel == 2) hi = DW'(1) << $urandom_range(DW-1, 0);
      runTest(lo, hi, $urandom_range(5, 0), ($urandom_range(1, 0) == 1));
    end

    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check("R1 passFlag after reset", passFlag, 0);
    check("R1 memReq after reset", memReq, 0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule